// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and presents them to a processor as two active-high requests: a normal one and a fast one. Each line can be enabled, steered to either request, given a 4-bit priority, and forced on by software. The lines are grouped into a low bank (sources 0 to 31) and a high bank (sources 32 to 63), and every per-source bit vector appears as a pair of 32-bit registers.

Software reaches all state through a simple synchronous register bus with an address, a write strobe, write data and registered read data. A handler reads the normal vector register to learn which pending normal source has the highest priority. It services that source, reads the vector again, and stops when the vector reads all-ones. A mask level stops the normal request whenever the winning priority does not exceed it.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset these registers read zero: control (0x00), both enable words, both type words and all eight priority words. The mask level (0x04) reads 0x1F, the normal vector (0x40) reads 0xFFFF0000, the fast vector (0x44) reads 0, and both request outputs are low.
- R2: Source s < 32 occupies bit s of a low word and source s >= 32 occupies bit s-32 of a high word. The word pairs (high/low) are: enable 0x10/0x14, type 0x18/0x1C, raw input 0x48/0x4C, force 0x50/0x54, normal pending 0x58/0x5C and fast pending 0x60/0x64. Enable, type and force are read/write, and the others are read-only.
- R3: A source is normal-pending when (raw input OR force) AND enable AND NOT type. It is fast-pending under the same condition with its type bit set.
- R4: The priority of source s is bits [4*(s%8)+3 : 4*(s%8)] of the word for group g = s/8, which sits at address 0x20 + 4*(7-g). Group 7 is at 0x20 and group 0 is at 0x3C.
- R5: The normal vector bits [31:16] hold the pending normal source with the highest priority. On equal priority the higher source number wins. The field reads 0xFFFF when no normal source is pending, and bits [15:0] read 0. Reading it changes no state, so repeated reads follow the live pending set.
- R6: irq_norm is registered and rises one cycle after a winner exists whose priority is strictly greater than mask level bits [3:0]. Setting mask level bit 4 (register 0x04 bits [4:0]) lets every winner through.
- R7: irq_fast is registered and is high one cycle after any source is fast-pending. The fast vector register (0x44) reads bit 0 = any fast-pending source, with all other bits 0.
- R8: Writing to 0x08 sets the enable bit of the source numbered by data bits [5:0], and writing to 0x0C clears it. No other enable bit changes, and both addresses read 0.
- R9: Read data appears on bus_rdata one clock after the address is presented. Control (0x00) reads back the last value written, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, commits on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 64 | Raw level-sensitive interrupt lines |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The bench goes after the reversed addressing of the priority words. It places sources in group 0 and group 7, so a design that mapped group g to 0x20 + 4*g would name the wrong winner. It creates a priority tie between sources 5 and 40, which a design that favoured the lower number would resolve wrongly. It sets the mask level equal to the winning priority, which a design comparing with >= would let through. It also walks the vector down to 0xFFFF by dropping lines one at a time, retypes a forced source as fast so it must vanish from the normal path, and writes number-based enable and disable with junk in the upper data bits, which a design decoding too many bits would mishandle.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
   // Register offsets (byte addresses); the map is fixed for a 32-bit bus.
   localparam int OFF_CTRL     = 'h00;
   localparam int OFF_MASKLVL  = 'h04;
   localparam int OFF_ENSET    = 'h08;
   localparam int OFF_ENCLR    = 'h0C;
   localparam int OFF_ENA_LO   = 'h14;   // high bank sits 4 bytes below
   localparam int OFF_TYP_LO   = 'h1C;
   localparam int OFF_PRIO_TOP = 'h20;   // highest group lives here
   localparam int OFF_NVEC     = 'h40;
   localparam int OFF_FVEC     = 'h44;
   localparam int OFF_RAW_LO   = 'h4C;
   localparam int OFF_FRC_LO   = 'h54;
   localparam int OFF_NPND_LO  = 'h5C;
   localparam int OFF_FPND_LO  = 'h64;

   typedef struct packed {
      logic found;
      logic [5:0] idx;
      logic [3:0] prio;
   } vp_win_t;
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
   import vpic_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [DATA_W-1:0]         ctrl_q,
   output logic [PRIO_W:0]           mask_lvl,
   output logic [NUM_SRC-1:0]        en_q,
   output logic [NUM_SRC-1:0]        typ_q,
   output logic [NUM_SRC-1:0]        frc_q,
   output logic [NUM_SRC*PRIO_W-1:0] prio_q
);
   localparam int BANKS  = NUM_SRC / DATA_W;
   localparam int SPW    = DATA_W / PRIO_W;
   localparam int GROUPS = NUM_SRC / SPW;
   localparam int IDX_W  = $clog2(NUM_SRC);

   logic [IDX_W-1:0]   num;
   logic [NUM_SRC-1:0] set_m, clr_m;

   assign num = wr_data[IDX_W-1:0];

   always_comb begin
      set_m = '0;
      clr_m = '0;
      if (wr_en && wr_addr == ADDR_W'(OFF_ENSET)) set_m[num] = 1'b1;
      if (wr_en && wr_addr == ADDR_W'(OFF_ENCLR)) clr_m[num] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         mask_lvl <= '1;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(OFF_CTRL))    ctrl_q   <= wr_data;
         if (wr_addr == ADDR_W'(OFF_MASKLVL)) mask_lvl <= wr_data[PRIO_W:0];
      end
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      localparam int EN_OFF = OFF_ENA_LO - 4*b;
      localparam int TY_OFF = OFF_TYP_LO - 4*b;
      localparam int FR_OFF = OFF_FRC_LO - 4*b;
      logic [DATA_W-1:0] en_r, ty_r, fr_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_r <= '0;
            ty_r <= '0;
            fr_r <= '0;
         end else begin
            if (wr_en && wr_addr == ADDR_W'(EN_OFF))
               en_r <= wr_data;
            else
               en_r <= (en_r | set_m[b*DATA_W +: DATA_W]) & ~clr_m[b*DATA_W +: DATA_W];
            if (wr_en && wr_addr == ADDR_W'(TY_OFF)) ty_r <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(FR_OFF)) fr_r <= wr_data;
         end
      end

      assign en_q [b*DATA_W +: DATA_W] = en_r;
      assign typ_q[b*DATA_W +: DATA_W] = ty_r;
      assign frc_q[b*DATA_W +: DATA_W] = fr_r;
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_prio
      localparam int PR_OFF = OFF_PRIO_TOP + 4*(GROUPS-1-g);
      logic [DATA_W-1:0] pr_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pr_r <= '0;
         else if (wr_en && wr_addr == ADDR_W'(PR_OFF))
            pr_r <= wr_data;
      end

      assign prio_q[g*DATA_W +: DATA_W] = pr_r;
   end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]        pend,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   output logic                      found,
   output logic [IDX_W-1:0]          win_idx,
   output logic [PRIO_W-1:0]         win_prio
);
   logic [PRIO_W-1:0] cur;

   // Ascending scan with >= lets the later (higher) source take ties.
   always_comb begin
      found    = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      cur      = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         cur = prio[s*PRIO_W +: PRIO_W];
         if (pend[s] && (!found || cur >= win_prio)) begin
            found    = 1'b1;
            win_idx  = IDX_W'(s);
            win_prio = cur;
         end
      end
   end
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
   import vpic_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic               irq_norm,
   output logic               irq_fast
);
   localparam int BANKS  = NUM_SRC / DATA_W;
   localparam int SPW    = DATA_W / PRIO_W;
   localparam int GROUPS = NUM_SRC / SPW;
   localparam int IDX_W  = $clog2(NUM_SRC);
   localparam int VEC_W  = DATA_W / 2;

   if (DATA_W != 32) begin : g_bad_width
      $error("vpic_ctrl: register map needs DATA_W == 32");
   end
   if (NUM_SRC != 2*DATA_W) begin : g_bad_count
      $error("vpic_ctrl: register map needs exactly two banks");
   end
   if (PRIO_W * SPW != DATA_W) begin : g_bad_prio
      $error("vpic_ctrl: PRIO_W must divide DATA_W");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("vpic_ctrl: ADDR_W too small for the map");
   end

   logic [DATA_W-1:0]         ctrl_q;
   logic [PRIO_W:0]           mask_lvl;
   logic [NUM_SRC-1:0]        en_q, typ_q, frc_q;
   logic [NUM_SRC*PRIO_W-1:0] prio_q;
   logic [NUM_SRC-1:0]        req_all, pend_n, pend_f;
   logic                      found;
   logic [IDX_W-1:0]          win_idx;
   logic [PRIO_W-1:0]         win_prio;
   logic [VEC_W-1:0]          vec_num;
   logic [DATA_W-1:0]         rd_next;
   logic                      norm_next;

   vpic_regs #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .wr_addr  (bus_addr),
      .wr_data  (bus_wdata),
      .ctrl_q   (ctrl_q),
      .mask_lvl (mask_lvl),
      .en_q     (en_q),
      .typ_q    (typ_q),
      .frc_q    (frc_q),
      .prio_q   (prio_q)
   );

   assign req_all = (src_in | frc_q) & en_q;
   assign pend_n  = req_all & ~typ_q;
   assign pend_f  = req_all &  typ_q;

   vpic_arbiter #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
   ) u_arb (
      .pend     (pend_n),
      .prio     (prio_q),
      .found    (found),
      .win_idx  (win_idx),
      .win_prio (win_prio)
   );

   assign vec_num   = found ? VEC_W'(win_idx) : {VEC_W{1'b1}};
   assign norm_next = found && (mask_lvl[PRIO_W] || win_prio > mask_lvl[PRIO_W-1:0]);

   always_comb begin
      rd_next = '0;
      if (bus_addr == ADDR_W'(OFF_CTRL))    rd_next = ctrl_q;
      if (bus_addr == ADDR_W'(OFF_MASKLVL)) rd_next = DATA_W'(mask_lvl);
      if (bus_addr == ADDR_W'(OFF_NVEC))    rd_next = {vec_num, {VEC_W{1'b0}}};
      if (bus_addr == ADDR_W'(OFF_FVEC))    rd_next = DATA_W'(|pend_f);
      for (int b = 0; b < BANKS; b++) begin
         if (bus_addr == ADDR_W'(OFF_ENA_LO  - 4*b)) rd_next = en_q  [b*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(OFF_TYP_LO  - 4*b)) rd_next = typ_q [b*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(OFF_RAW_LO  - 4*b)) rd_next = src_in[b*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(OFF_FRC_LO  - 4*b)) rd_next = frc_q [b*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(OFF_NPND_LO - 4*b)) rd_next = pend_n[b*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(OFF_FPND_LO - 4*b)) rd_next = pend_f[b*DATA_W +: DATA_W];
      end
      for (int g = 0; g < GROUPS; g++) begin
         if (bus_addr == ADDR_W'(OFF_PRIO_TOP + 4*(GROUPS-1-g)))
            rd_next = prio_q[g*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         irq_norm  <= 1'b0;
         irq_fast  <= 1'b0;
      end else begin
         bus_rdata <= rd_next;
         irq_norm  <= norm_next;
         irq_fast  <= |pend_f;
      end
   end
endmodule

// File: rtl/vpic_ctrl_chk.sv
module vpic_ctrl_chk
   import vpic_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [DATA_W-1:0]         bus_rdata,
   input logic                      irq_norm,
   input logic                      irq_fast,
   input logic [NUM_SRC-1:0]        pend_n,
   input logic [NUM_SRC-1:0]        pend_f,
   input logic                      found,
   input logic [IDX_W-1:0]          win_idx,
   input logic [PRIO_W-1:0]         win_prio,
   input logic [NUM_SRC*PRIO_W-1:0] prio_q,
   input logic [PRIO_W:0]           mask_lvl
);
   logic              beaten;
   logic [PRIO_W-1:0] p;

   // Any pending source that should have outranked the reported winner.
   always_comb begin
      beaten = 1'b0;
      p      = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         p = prio_q[s*PRIO_W +: PRIO_W];
         if (found && pend_n[s] &&
             (p > win_prio || (p == win_prio && IDX_W'(s) > win_idx)))
            beaten = 1'b1;
      end
   end

   assert_winner_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> pend_n[win_idx]);

   assert_none_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (pend_n == '0));

   assert_winner_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !beaten);

   assert_fast_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_fast == $past(|pend_f)));

   assert_norm_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_norm == ($past(found) &&
                ($past(mask_lvl[PRIO_W]) || $past(win_prio) > $past(mask_lvl[PRIO_W-1:0])))));

   assert_num_regs_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_ENSET) || bus_addr == ADDR_W'(OFF_ENCLR)) |=> (bus_rdata == '0));
endmodule

bind vpic_ctrl vpic_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq_norm  (irq_norm),
   .irq_fast  (irq_fast),
   .pend_n    (pend_n),
   .pend_f    (pend_f),
   .found     (found),
   .win_idx   (win_idx),
   .win_prio  (win_prio),
   .prio_q    (prio_q),
   .mask_lvl  (mask_lvl)
);

// File: tb/vpic_ctrl_tb.sv
module vpic_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_addr;
   logic        bus_wr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [63:0] src_in;
   logic        irq_norm;
   logic        irq_fast;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   rd_item_t sb_q[$];

   always #2 clk = ~clk;

   vpic_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
      .irq_norm(irq_norm), .irq_fast(irq_fast)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   // Driver: present the address and queue the expected data.
   task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_addr = a;
      sb_q.push_back('{exp: e, tag: tag});
   endtask

   task automatic chk_irq(input logic en, input logic ef, input string tag);
      @(negedge clk);
      check(irq_norm === en, {tag, " irq_norm"}, 32'(irq_norm), 32'(en));
      check(irq_fast === ef, {tag, " irq_fast"}, 32'(irq_fast), 32'(ef));
   endtask

   // Monitor: read data registered on the edge after the address.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            rd_item_t it;
            it = sb_q.pop_front();
            check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; src_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      bus_read(8'h00, 32'h0, "R1 control");
      bus_read(8'h04, 32'h1F, "R1 mask level");
      bus_read(8'h10, 32'h0, "R1 enable hi");
      bus_read(8'h14, 32'h0, "R1 enable lo");
      bus_read(8'h18, 32'h0, "R1 type hi");
      bus_read(8'h1C, 32'h0, "R1 type lo");
      for (int g = 0; g < 8; g++) bus_read(8'(32 + 4*g), 32'h0, "R1 priority");
      bus_read(8'h40, 32'hFFFF_0000, "R1 normal vector");
      bus_read(8'h44, 32'h0, "R1 fast vector");
      chk_irq(1'b0, 1'b0, "R1");

      // R9: unmapped and control readback
      bus_read(8'h68, 32'h0, "R9 unmapped");
      bus_write(8'h00, 32'hA5A5_0F0F);
      bus_read(8'h00, 32'hA5A5_0F0F, "R9 control");

      // R8: enable / disable by number
      bus_write(8'h08, 32'd5);
      bus_read(8'h14, 32'h0000_0020, "R8 set 5");
      bus_write(8'h08, 32'd40);
      bus_read(8'h10, 32'h0000_0100, "R8 set 40");
      bus_read(8'h08, 32'h0, "R8 set reads 0");
      bus_read(8'h0C, 32'h0, "R8 clear reads 0");
      bus_write(8'h0C, 32'hFFFF_FFC5);
      bus_read(8'h14, 32'h0, "R8 clear 5");
      bus_read(8'h10, 32'h0000_0100, "R8 others kept");

      // R2/R3: raw lines and pending
      @(negedge clk);
      src_in = (64'd1 << 5) | (64'd1 << 40);
      bus_read(8'h4C, 32'h0000_0020, "R2 raw lo");
      bus_read(8'h48, 32'h0000_0100, "R2 raw hi");
      bus_read(8'h5C, 32'h0, "R3 disabled not pending");
      bus_read(8'h58, 32'h0000_0100, "R3 pending hi");
      bus_read(8'h40, 32'h0028_0000, "R5 single winner");
      chk_irq(1'b1, 1'b0, "R6 mask bit4 open");

      // R6/R4: mask level against priority
      bus_write(8'h04, 32'h0);
      chk_irq(1'b0, 1'b0, "R6 prio 0 not above 0");
      bus_write(8'h28, 32'h3);
      bus_read(8'h28, 32'h3, "R4 group 5 word");
      chk_irq(1'b1, 1'b0, "R6 prio 3 above 0");
      bus_write(8'h04, 32'h3);
      chk_irq(1'b0, 1'b0, "R6 equal is masked");
      bus_write(8'h04, 32'h2);
      chk_irq(1'b1, 1'b0, "R6 above mask");

      // R5: ties and ordering
      bus_write(8'h14, 32'h0000_0020);
      bus_read(8'h5C, 32'h0000_0020, "R3 pending lo");
      bus_read(8'h40, 32'h0028_0000, "R5 higher prio wins");
      bus_write(8'h3C, 32'h0030_0000);
      bus_read(8'h40, 32'h0028_0000, "R5 tie to higher number");
      bus_write(8'h3C, 32'h0040_0000);
      bus_read(8'h40, 32'h0005_0000, "R4 group 0 at 0x3C");
      bus_read(8'h40, 32'h0005_0000, "R5 read does not clear");
      chk_irq(1'b1, 1'b0, "R6 winner 5");

      // R3/R4: forced source in group 7
      bus_write(8'h50, 32'h8000_0000);
      bus_write(8'h08, 32'd63);
      bus_write(8'h20, 32'hF000_0000);
      bus_read(8'h58, 32'h8000_0100, "R3 force pending");
      bus_read(8'h40, 32'h003F_0000, "R4 group 7 at 0x20");
      bus_read(8'h50, 32'h8000_0000, "R2 force hi");

      // R7: route 63 to fast
      bus_write(8'h18, 32'h8000_0000);
      bus_read(8'h60, 32'h8000_0000, "R7 fast pending hi");
      bus_read(8'h64, 32'h0, "R7 fast pending lo");
      bus_read(8'h58, 32'h0000_0100, "R3 fast leaves normal");
      bus_read(8'h44, 32'h1, "R7 fast vector");
      bus_read(8'h40, 32'h0005_0000, "R5 winner after retype");
      chk_irq(1'b1, 1'b1, "R7 both");
      bus_write(8'h04, 32'h4);
      chk_irq(1'b0, 1'b1, "R6 mask stops normal only");

      // R5: drain at the source
      @(negedge clk);
      src_in[5] = 1'b0;
      bus_read(8'h40, 32'h0028_0000, "R5 next winner");
      @(negedge clk);
      src_in = '0;
      bus_read(8'h40, 32'hFFFF_0000, "R5 all clear");
      bus_write(8'h50, 32'h0);
      bus_read(8'h44, 32'h0, "R7 fast cleared");
      chk_irq(1'b0, 1'b0, "R7 idle");

      repeat (4) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule